// File: doc/BRIEF.md
# Self-Timed Flash Write Sequencer

This block carries out erase and byte-program operations on a small behavioural flash array once an upstream command decoder hands it a start request. Each operation runs through a settle period that stands in for the high-voltage pulse, an apply phase that writes the array, and a read-back phase that checks the result. A lock-free status pair tells the host how the operation ended. The ready output is low while work is in progress. The timeout output is raised by an internal watchdog if the operation has not finished within its limit.

Ready returning high means the operation passed. Timeout rising while ready is still low means it failed. The sequencer accepts a new request when it is idle, or after a failure, and that request also clears the timeout. Requests that arrive while an operation is in progress have no effect. The settle time and the timeout limit of each of the four operations are separate parameters. They are scaled down to cycle counts that suit simulation.

Top module: `flash_write_seq`

## Requirements
- R1: After reset, ready is 1, timeout is 0, and every array byte reads all ones (erased).
- R2: A start accepted while ready is 1 drives ready to 0 in the following cycle. Ready stays 0 until the apply and read-back phases are both complete, and then returns to 1.
- R3: The `op` codes are 0 = whole-array erase (every address), 1 = lower-region erase (addresses 0 to HI_BASE-1), 2 = upper-region erase (HI_BASE to the top address), and 3 = byte program. Each erase sets every byte in its range to all ones.
- R4: A region erase leaves every byte outside its own range unchanged, including the bytes on either side of the HI_BASE boundary.
- R5: A byte program stores the old byte ANDed with `wdata` at `addr`. When the stored byte then equals `wdata`, ready returns to 1.
- R6: If the read-back after a program does not match, ready stays 0 and timeout rises TMO_PROG cycles after the accepting edge. Timeout is never 1 while ready is 1.
- R7: A start that arrives while an operation is in progress has no effect on the array contents or on the running operation.
- R8: A start accepted while timeout is 1 clears timeout in the following cycle, restarts the watchdog, and begins the new operation.
- R9: Each operation keeps ready low for at least its DUR_* parameter in cycles, and a passing operation finishes before its TMO_* limit.
- R10: `rd_data` shows the byte at `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle operation request from the command decoder |
| op | input | 2 | Operation code (see R3) |
| addr | input | AW | Byte address used by program |
| wdata | input | DW | Data byte used by program |
| rd_addr | input | AW | Array read address |
| rd_data | output | DW | Array byte at rd_addr |
| ready | output | 1 | 1 when idle; 0 while an operation runs or has failed |
| timeout | output | 1 | 1 when the watchdog has expired on the last operation |

## Verification
The hardest state to reach from the ports is a failed program. An erase cannot fail in this array model, so the only way to fail is to program a byte that is not erased. The stimulus first programs a byte with a value that clears some bits. It then programs the same byte with data that needs those bits set again. This drives the read-back mismatch, and the bench counts cycles up to the timeout rise. A further start issued while the block sits in that failed state exercises the timeout clear and the watchdog restart. A second awkward case is a start sent in the middle of an erase. The bench shows it was ignored by checking that the target byte is untouched afterwards.

// File: rtl/flseq_pkg.sv
// Shared types for the flash write sequencer.
package flseq_pkg;
    // Operation codes presented on the op input.
    typedef enum logic [1:0] {
        OP_CHIP = 2'd0,
        OP_LOW  = 2'd1,
        OP_HIGH = 2'd2,
        OP_PROG = 2'd3
    } flop_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        S_IDLE, S_PULSE, S_APPLY, S_VERIFY, S_HANG, S_FAIL
    } fstate_e;
endpackage

// File: rtl/flseq_array.sv
// Behavioural flash byte array.
// Provides one synchronous write port and two combinational read ports:
// one for the sequencer's read-back and one for the host.
// Assumes the array starts erased (all ones) after reset.
module flseq_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] va_addr,
    output logic [DW-1:0] va_data,
    input  logic [AW-1:0] hb_addr,
    output logic [DW-1:0] hb_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Storage: reset to the erased value, then accept single-byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read ports: combinational look-up.
    always_comb begin
        va_data = mem[va_addr];
        hb_data = mem[hb_addr];
    end
endmodule

// File: rtl/flseq_timer.sv
// Operation watchdog.
// Cleared and restarted by an accepted start; counts while the sequencer is
// busy and raises expired once the count reaches the limit of the current
// operation. Expired holds until the next accepted start.
module flseq_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Counter and expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (clear) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (run && !expired) begin
            if (cnt == limit - CW'(1)) expired <= 1'b1;
            else                       cnt     <= cnt + CW'(1);
        end
    end

    // R6: expiry only ever begins while an operation is running.
    assert_expiry_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(run));
    // R8: a clear always drops the expiry flag.
    assert_clear_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired);
endmodule

// File: rtl/flseq_ctrl.sv
// Sequencer control.
// Accepts a request when idle or failed, waits the settle time of the
// operation, writes its address range one byte per cycle, then reads the
// range back. A mismatch parks it in a hang state until the watchdog expires.
// Assumes DUR_* >= 1 and that each TMO_* exceeds the settle time plus the
// apply and read-back sweep of its range.
module flseq_ctrl
    import flseq_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int CW       = 10,
    parameter int HI_BASE  = 224,
    parameter int DUR_CHIP = 40,
    parameter int DUR_LOW  = 30,
    parameter int DUR_HIGH = 20,
    parameter int DUR_PROG = 8,
    parameter int TMO_CHIP = 600,
    parameter int TMO_LOW  = 500,
    parameter int TMO_HIGH = 120,
    parameter int TMO_PROG = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          expired,
    input  logic [DW-1:0] va_data,
    output logic [AW-1:0] va_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          busy,
    output logic          accept,
    output logic          idle,
    output logic [CW-1:0] tmo_limit
);
    fstate_e       state;
    flop_e         op_q;
    flop_e         op_in;
    logic [DW-1:0] data_q;
    logic [AW-1:0] ptr, lo_q, hi_q, lo_in, hi_in;
    logic [CW-1:0] dcnt, dur;
    logic [DW-1:0] expect_v;

    // Range decode for an incoming request.
    always_comb begin
        op_in = flop_e'(op);
        case (op_in)
            OP_LOW:  begin lo_in = '0;            hi_in = AW'(HI_BASE - 1); end
            OP_HIGH: begin lo_in = AW'(HI_BASE);  hi_in = '1;               end
            OP_PROG: begin lo_in = addr;          hi_in = addr;             end
            default: begin lo_in = '0;            hi_in = '1;               end
        endcase
    end

    // Per-operation settle time and watchdog limit.
    always_comb begin
        case (op_q)
            OP_LOW:  begin dur = CW'(DUR_LOW);  tmo_limit = CW'(TMO_LOW);  end
            OP_HIGH: begin dur = CW'(DUR_HIGH); tmo_limit = CW'(TMO_HIGH); end
            OP_PROG: begin dur = CW'(DUR_PROG); tmo_limit = CW'(TMO_PROG); end
            default: begin dur = CW'(DUR_CHIP); tmo_limit = CW'(TMO_CHIP); end
        endcase
    end

    // Handshake, array access and expected read-back value.
    always_comb begin
        idle     = (state == S_IDLE);
        busy     = (state == S_PULSE) || (state == S_APPLY) ||
                   (state == S_VERIFY) || (state == S_HANG);
        accept   = start && ((state == S_IDLE) || (state == S_FAIL));
        expect_v = (op_q == OP_PROG) ? data_q : '1;
        va_addr  = ptr;
        wr_addr  = ptr;
        wr_en    = (state == S_APPLY) && !expired;
        wr_data  = (op_q == OP_PROG) ? (va_data & data_q) : '1;
    end

    // Sequencer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= OP_CHIP;
            data_q <= '0;
            ptr    <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            dcnt   <= '0;
        end else if (accept) begin
            state  <= S_PULSE;
            op_q   <= op_in;
            data_q <= wdata;
            ptr    <= lo_in;
            lo_q   <= lo_in;
            hi_q   <= hi_in;
            dcnt   <= '0;
        end else if (busy && expired) begin
            state <= S_FAIL;
        end else begin
            case (state)
                S_PULSE: begin
                    if (dcnt == dur - CW'(1)) state <= S_APPLY;
                    else                      dcnt  <= dcnt + CW'(1);
                end
                S_APPLY: begin
                    if (ptr == hi_q) begin
                        state <= S_VERIFY;
                        ptr   <= lo_q;
                    end else begin
                        ptr <= ptr + AW'(1);
                    end
                end
                S_VERIFY: begin
                    if (va_data != expect_v) state <= S_HANG;
                    else if (ptr == hi_q)    state <= S_IDLE;
                    else                     ptr   <= ptr + AW'(1);
                end
                default: ;
            endcase
        end
    end

    // R7: a request during a running operation leaves the operation as it was.
    assert_busy_op_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(op_q) && $stable(hi_q));
    // R6: the failed state is entered only after the watchdog expired.
    assert_fail_needs_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == S_FAIL) |-> $past(expired));
    // R2: the idle state is reached only from a finished read-back.
    assert_idle_after_verify_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == S_IDLE) |-> $past(state == S_VERIFY));
endmodule

// File: rtl/flash_write_seq.sv
// Self-timed flash write sequencer top level.
// Joins the control state machine, the watchdog and the array model.
// Ready is high only when idle; timeout follows the watchdog flag.
module flash_write_seq #(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int HI_BASE  = 224,
    parameter int DUR_CHIP = 40,
    parameter int DUR_LOW  = 30,
    parameter int DUR_HIGH = 20,
    parameter int DUR_PROG = 8,
    parameter int TMO_CHIP = 600,
    parameter int TMO_LOW  = 500,
    parameter int TMO_HIGH = 120,
    parameter int TMO_PROG = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          ready,
    output logic          timeout
);
    localparam int TMAX_A = (TMO_CHIP > TMO_LOW)  ? TMO_CHIP : TMO_LOW;
    localparam int TMAX_B = (TMO_HIGH > TMO_PROG) ? TMO_HIGH : TMO_PROG;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int CW     = $clog2(TMAX + 1);

    logic          expired, busy, accept, idle, wr_en;
    logic [CW-1:0] tmo_limit;
    logic [AW-1:0] va_addr, wr_addr;
    logic [DW-1:0] va_data, wr_data;

    flseq_ctrl #(
        .AW(AW), .DW(DW), .CW(CW), .HI_BASE(HI_BASE),
        .DUR_CHIP(DUR_CHIP), .DUR_LOW(DUR_LOW), .DUR_HIGH(DUR_HIGH), .DUR_PROG(DUR_PROG),
        .TMO_CHIP(TMO_CHIP), .TMO_LOW(TMO_LOW), .TMO_HIGH(TMO_HIGH), .TMO_PROG(TMO_PROG)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
        .expired(expired), .va_data(va_data), .va_addr(va_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .accept(accept),
        .idle(idle), .tmo_limit(tmo_limit)
    );

    flseq_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy),
        .limit(tmo_limit), .expired(expired)
    );

    flseq_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .va_addr(va_addr), .va_data(va_data), .hb_addr(rd_addr), .hb_data(rd_data)
    );

    // Status outputs.
    always_comb begin
        ready   = idle;
        timeout = expired;
    end

    // R6: the two status outputs never both report a finished state.
    assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !ready);
    // R2: an accepted request takes ready low on the next cycle.
    assert_start_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready);
endmodule

// File: tb/tb_flash_write_seq.sv
module tb_flash_write_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8, DW = 8, HI_BASE = 224;
    localparam int DUR_CHIP = 40, DUR_LOW = 30, DUR_HIGH = 20, DUR_PROG = 8;
    localparam int TMO_CHIP = 600, TMO_LOW = 500, TMO_HIGH = 120, TMO_PROG = 30;

    logic clk = 0, rst_n = 0, start = 0;
    logic [1:0] op = 0;
    logic [AW-1:0] addr = 0, rd_addr = 0;
    logic [DW-1:0] wdata = 0, rd_data;
    logic ready, timeout;
    int checks = 0, errors = 0;

    flash_write_seq #(
        .AW(AW), .DW(DW), .HI_BASE(HI_BASE),
        .DUR_CHIP(DUR_CHIP), .DUR_LOW(DUR_LOW), .DUR_HIGH(DUR_HIGH), .DUR_PROG(DUR_PROG),
        .TMO_CHIP(TMO_CHIP), .TMO_LOW(TMO_LOW), .TMO_HIGH(TMO_HIGH), .TMO_PROG(TMO_PROG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready), .timeout(timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic rd_chk(input string req, input int a, input int exp_v);
        rd_addr = AW'(a);
        #1;
        check(req, int'(rd_data), exp_v);
    endtask

    // Pulse start for one cycle; returns at the negedge after the accepting edge.
    task automatic pulse(input int o, input int a, input int d);
        @(negedge clk);
        start = 1; op = 2'(o); addr = AW'(a); wdata = DW'(d);
        @(negedge clk);
        start = 0;
    endtask

    // Run an operation and count the cycles with ready low.
    task automatic run_op(input int o, input int a, input int d, output int k);
        pulse(o, a, d);
        k = 1;
        while (!ready && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic t_reset;
        check("R1 ready after reset", int'(ready), 1);
        check("R1 timeout after reset", int'(timeout), 0);
        rd_chk("R1 erased byte 0", 0, 8'hFF);
        rd_chk("R10 erased top byte", 255, 8'hFF);
    endtask

    task automatic t_program;
        int k;
        pulse(3, 3, 8'h5A);
        check("R2 ready low after start", int'(ready), 0);
        k = 1;
        while (!ready && k < 2000) begin @(negedge clk); k++; end
        check_range("R9 program busy window", k, DUR_PROG, TMO_PROG - 1);
        check("R5 no timeout on pass", int'(timeout), 0);
        rd_chk("R5 program addr 3", 3, 8'h5A);
        run_op(3, 230, 8'hA5, k);
        run_op(3, 100, 8'h3C, k);
        run_op(3, HI_BASE - 1, 8'h11, k);
        run_op(3, HI_BASE, 8'h22, k);
        rd_chk("R5 program addr 230", 230, 8'hA5);
        rd_chk("R10 program boundary low", HI_BASE - 1, 8'h11);
    endtask

    task automatic t_region_erase;
        int k;
        run_op(2, 0, 0, k);
        check_range("R9 upper erase busy window", k, DUR_HIGH, TMO_HIGH - 1);
        rd_chk("R3 upper erase 230", 230, 8'hFF);
        rd_chk("R3 upper erase base", HI_BASE, 8'hFF);
        rd_chk("R4 upper erase keeps base-1", HI_BASE - 1, 8'h11);
        rd_chk("R4 upper erase keeps 3", 3, 8'h5A);
        run_op(3, 240, 8'h44, k);
        run_op(1, 0, 0, k);
        check_range("R9 lower erase busy window", k, DUR_LOW, TMO_LOW - 1);
        rd_chk("R3 lower erase 3", 3, 8'hFF);
        rd_chk("R3 lower erase base-1", HI_BASE - 1, 8'hFF);
        rd_chk("R3 lower erase 100", 100, 8'hFF);
        rd_chk("R4 lower erase keeps 240", 240, 8'h44);
    endtask

    task automatic t_ignore_busy;
        int k;
        pulse(2, 0, 0);
        repeat (5) @(negedge clk);
        start = 1; op = 2'd3; addr = AW'(5); wdata = 8'h00;
        @(negedge clk);
        start = 0;
        k = 7;
        while (!ready && k < 2000) begin @(negedge clk); k++; end
        check_range("R7 erase ran to normal end", k, DUR_HIGH, TMO_HIGH - 1);
        rd_chk("R7 ignored program left addr 5", 5, 8'hFF);
        rd_chk("R7 erase still applied 240", 240, 8'hFF);
    endtask

    task automatic t_fail_recover;
        int k;
        run_op(3, 10, 8'h0F, k);
        rd_chk("R5 first program addr 10", 10, 8'h0F);
        pulse(3, 10, 8'hF0);
        k = 1;
        while (!timeout && k < 2000) begin
            if (ready) begin
                errors++; checks++;
                $display("FAIL R6 ready high during failed program actual=1 expected=0");
            end
            @(negedge clk);
            k++;
        end
        check_range("R6 timeout delay", k, TMO_PROG - 1, TMO_PROG + 1);
        repeat (3) @(negedge clk);
        check("R6 ready held low after failure", int'(ready), 0);
        check("R6 timeout held high", int'(timeout), 1);
        rd_chk("R5 AND applied to non-erased byte", 10, 8'h00);
        run_op(3, 200, 8'h66, k);
        check("R8 timeout cleared by new start", int'(timeout), 0);
        check("R8 new program completed", int'(ready), 1);
        rd_chk("R8 new program stored", 200, 8'h66);
    endtask

    task automatic t_chip_erase;
        int k;
        run_op(3, 255, 8'h77, k);
        pulse(0, 0, 0);
        check("R2 ready low at chip erase start", int'(ready), 0);
        k = 1;
        while (!ready && k < 2000) begin @(negedge clk); k++; end
        check_range("R9 chip erase busy window", k, DUR_CHIP, TMO_CHIP - 1);
        check("R2 ready back high", int'(ready), 1);
        rd_chk("R3 chip erase addr 10", 10, 8'hFF);
        rd_chk("R3 chip erase addr 255", 255, 8'hFF);
        rd_chk("R3 chip erase addr 200", 200, 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_program();
        t_region_erase();
        t_ignore_busy();
        t_fail_recover();
        t_chip_erase();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule